// File: doc/BRIEF.md
# Aligned Frame Pulse Generator

This block turns a fast system clock into two slow framing outputs. The fast frame output runs at 8 kHz and the slow frame output at 2 kHz. With the default 19.44 MHz input clock, one fast period lasts 2430 cycles and one slow period lasts 9720 cycles. Both outputs are decoded from one shared phase counter. A slow period is exactly four fast periods, so every slow rising edge lands on a fast rising edge.

Each output has its own shape select and its own enable. The shape is either a 50% square wave or a pulse whose width is set in input clock cycles. A disabled output is driven low, and its output-enable signal drops so the pad driver can go to high impedance. A new shape or width takes effect only at the start of the next period of that output, which prevents runt pulses. A synchronous reset puts the counter back to phase zero, so both outputs restart together.

Top module: `frame_pulse_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `fast_clk`, `fast_oe`, `slow_clk` and `slow_oe` are all 0 after that edge. The first edge with `rst_n` high is phase 0 of both outputs.
- R2: Counting edges from the first edge after reset release as k = 0, 1, 2, ..., the value of an enabled output after edge k belongs to phase k mod 2430 for the fast output and k mod 9720 for the slow output. Every period starts high at phase 0.
- R3: With the shape select at 0 (square), an output is high for phases below half its period: 1215 fast, 4860 slow. It is low for the rest of the period.
- R4: With the shape select at 1 (pulse), an output is high for phases below the programmed width and low for the rest of the period.
- R5: A programmed width of 0 acts as 1. A width equal to or greater than the period acts as period minus 1.
- R6: Shape select and width are captured at phase 0 of each output's own period. Changes made at any other phase have no effect until the next phase 0.
- R7: Each output-enable equals its enable input from one edge earlier. While an output is disabled, its output reads 0. The two channels are independent.
- R8: When both outputs are enabled, every rising edge of `slow_clk` happens in the same cycle as a rising edge of `fast_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesized system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fast_en | input | 1 | Enable for the 8 kHz output |
| fast_pulse_mode | input | 1 | 0 square, 1 programmable pulse (8 kHz) |
| fast_width | input | 14 | Pulse width in clock cycles (8 kHz) |
| slow_en | input | 1 | Enable for the 2 kHz output |
| slow_pulse_mode | input | 1 | 0 square, 1 programmable pulse (2 kHz) |
| slow_width | input | 14 | Pulse width in clock cycles (2 kHz) |
| fast_clk | output | 1 | 8 kHz frame output |
| fast_oe | output | 1 | Output enable for the 8 kHz pad |
| slow_clk | output | 1 | 2 kHz frame output |
| slow_oe | output | 1 | Output enable for the 2 kHz pad |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- **Width extremes (0, period minus 1, period, all ones).** A design without clamping would emit no pulse at all, or hold the output high through a whole period.
- **Width and shape changes in mid-period.** A design that applies them at once would produce truncated or stretched pulses.
- **Reset asserted mid-run, and enable toggled at arbitrary phases.** These expose a counter that does not restart at phase 0, or an output-enable that is not tied to its own channel.
- **Slow wrap against fast wrap.** The bench checks every slow rising edge against the fast output, which catches an off-by-one in the slow period that would let the two rates drift apart.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    typedef enum logic {
        SHAPE_SQUARE = 1'b0,
        SHAPE_PULSE  = 1'b1
    } shape_e;

    localparam int unsigned FPG_DEF_FAST_PERIOD = 2430;
    localparam int unsigned FPG_DEF_RATIO       = 4;

endpackage

// File: rtl/fpg_phase_counter.sv
module fpg_phase_counter #(
    parameter int unsigned FAST_PERIOD = 2430,
    parameter int unsigned RATIO       = 4,
    parameter int unsigned CNT_W       = $clog2(FAST_PERIOD * RATIO)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] fast_phase,
    output logic [CNT_W-1:0] slow_phase,
    output logic             fast_start,
    output logic             slow_start
);

    localparam int unsigned IDX_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CNT_W-1:0] SUB_LAST = CNT_W'(FAST_PERIOD - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(RATIO - 1);
    localparam logic [CNT_W-1:0] FAST_P   = CNT_W'(FAST_PERIOD);

    typedef struct packed {
        logic [CNT_W-1:0] sub;
        logic [IDX_W-1:0] idx;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    // Mixed-radix counter: sub counts inside a fast period, idx counts fast periods
    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q.sub == SUB_LAST) begin
            cnt_d.sub = '0;
            cnt_d.idx = (cnt_q.idx == IDX_LAST) ? '0 : cnt_q.idx + IDX_W'(1);
        end else begin
            cnt_d.sub = cnt_q.sub + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign fast_phase = cnt_q.sub;
    assign slow_phase = (CNT_W'(cnt_q.idx) * FAST_P) + cnt_q.sub;
    assign fast_start = (cnt_q.sub == '0);
    assign slow_start = (cnt_q.sub == '0) && (cnt_q.idx == '0);

endmodule

// File: rtl/fpg_shaper.sv
module fpg_shaper
    import fpg_pkg::*;
#(
    parameter int unsigned PERIOD = 2430,
    parameter int unsigned CNT_W  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] phase,
    input  logic             start,
    input  logic             en,
    input  logic             pulse_mode,
    input  logic [CNT_W-1:0] width,
    output logic             wave,
    output logic             oe
);

    localparam logic [CNT_W-1:0] PMAX = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(PERIOD / 2);

    typedef struct packed {
        logic             wave;
        logic             oe;
        shape_e           shape;
        logic [CNT_W-1:0] width;
    } shp_t;

    shp_t shp_d, shp_q;

    logic [CNT_W-1:0] clamped;
    shape_e           eff_shape;
    logic [CNT_W-1:0] eff_width;
    logic             level;

    always_comb begin
        // limit the request to 1 .. PERIOD-1
        if (width == '0) begin
            clamped = CNT_W'(1);
        end else if (width > PMAX) begin
            clamped = PMAX;
        end else begin
            clamped = width;
        end

        // new settings are taken only at phase zero
        eff_shape = start ? shape_e'(pulse_mode) : shp_q.shape;
        eff_width = start ? clamped : shp_q.width;

        if (eff_shape == SHAPE_PULSE) begin
            level = (phase < eff_width);
        end else begin
            level = (phase < HALF);
        end

        shp_d       = shp_q;
        shp_d.shape = eff_shape;
        shp_d.width = eff_width;
        shp_d.wave  = en & level;
        shp_d.oe    = en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shp_q.wave  <= 1'b0;
            shp_q.oe    <= 1'b0;
            shp_q.shape <= SHAPE_SQUARE;
            shp_q.width <= HALF;
        end else begin
            shp_q <= shp_d;
        end
    end

    assign wave = shp_q.wave;
    assign oe   = shp_q.oe;

endmodule

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen #(
    parameter int unsigned FAST_PERIOD = fpg_pkg::FPG_DEF_FAST_PERIOD,
    parameter int unsigned RATIO       = fpg_pkg::FPG_DEF_RATIO,
    parameter int unsigned CNT_W       = $clog2(FAST_PERIOD * RATIO)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_en,
    input  logic             fast_pulse_mode,
    input  logic [CNT_W-1:0] fast_width,
    input  logic             slow_en,
    input  logic             slow_pulse_mode,
    input  logic [CNT_W-1:0] slow_width,
    output logic             fast_clk,
    output logic             fast_oe,
    output logic             slow_clk,
    output logic             slow_oe
);

    localparam int unsigned SLOW_PERIOD = FAST_PERIOD * RATIO;
    localparam int unsigned NCH         = 2;

    logic [CNT_W-1:0] phase_v [NCH];
    logic [CNT_W-1:0] width_v [NCH];
    logic [NCH-1:0]   start_v;
    logic [NCH-1:0]   en_v;
    logic [NCH-1:0]   mode_v;
    logic [NCH-1:0]   wave_v;
    logic [NCH-1:0]   oe_v;

    fpg_phase_counter #(
        .FAST_PERIOD(FAST_PERIOD),
        .RATIO      (RATIO),
        .CNT_W      (CNT_W)
    ) i_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_phase(phase_v[0]),
        .slow_phase(phase_v[1]),
        .fast_start(start_v[0]),
        .slow_start(start_v[1])
    );

    assign en_v    = {slow_en, fast_en};
    assign mode_v  = {slow_pulse_mode, fast_pulse_mode};
    assign width_v[0] = fast_width;
    assign width_v[1] = slow_width;

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        fpg_shaper #(
            .PERIOD((gi == 0) ? FAST_PERIOD : SLOW_PERIOD),
            .CNT_W (CNT_W)
        ) i_shaper (
            .clk       (clk),
            .rst_n     (rst_n),
            .phase     (phase_v[gi]),
            .start     (start_v[gi]),
            .en        (en_v[gi]),
            .pulse_mode(mode_v[gi]),
            .width     (width_v[gi]),
            .wave      (wave_v[gi]),
            .oe        (oe_v[gi])
        );
    end

    assign fast_clk = wave_v[0];
    assign fast_oe  = oe_v[0];
    assign slow_clk = wave_v[1];
    assign slow_oe  = oe_v[1];

endmodule

// File: rtl/fpg_checker.sv
module fpg_checker #(
    parameter int unsigned FAST_PERIOD = 2430,
    parameter int unsigned RATIO       = 4
) (
    input logic clk,
    input logic rst_n,
    input logic fast_en,
    input logic slow_en,
    input logic fast_clk,
    input logic fast_oe,
    input logic slow_clk,
    input logic slow_oe
);

    localparam int unsigned SLOW_PERIOD = FAST_PERIOD * RATIO;

    // independent phase trackers, counted from reset release
    int unsigned f_ref, s_ref;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_ref <= 0;
            s_ref <= 0;
        end else begin
            f_ref <= (f_ref == FAST_PERIOD - 1) ? 0 : f_ref + 1;
            s_ref <= (s_ref == SLOW_PERIOD - 1) ? 0 : s_ref + 1;
        end
    end

    assert_fast_rise_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fast_clk) && $past(fast_oe)) |-> (f_ref == 1));

    assert_slow_rise_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(slow_clk) && $past(slow_oe)) |-> (s_ref == 1));

    assert_fast_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_oe |-> !fast_clk);

    assert_slow_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_oe |-> !slow_clk);

    assert_fast_oe_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fast_oe == $past(fast_en)));

    assert_slow_oe_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (slow_oe == $past(slow_en)));

    assert_edges_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(slow_clk) && $past(slow_oe) && $past(fast_oe) && fast_oe) |-> $rose(fast_clk));

endmodule

bind frame_pulse_gen fpg_checker #(
    .FAST_PERIOD(FAST_PERIOD),
    .RATIO      (RATIO)
) i_fpg_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .fast_en (fast_en),
    .slow_en (slow_en),
    .fast_clk(fast_clk),
    .fast_oe (fast_oe),
    .slow_clk(slow_clk),
    .slow_oe (slow_oe)
);

// File: tb/test_frame_pulse_gen.sv
`timescale 1ns/1ps
module test_frame_pulse_gen;

    localparam int FP  = 2430;
    localparam int SP  = 9720;
    localparam int CW  = 14;
    localparam int RUN = 60000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fast_en = 1'b1, slow_en = 1'b1;
    logic          fast_pulse_mode = 1'b0, slow_pulse_mode = 1'b0;
    logic [CW-1:0] fast_width = 14'd100, slow_width = 14'd100;
    logic          fast_clk, fast_oe, slow_clk, slow_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    frame_pulse_gen i_frame_pulse_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .fast_en        (fast_en),
        .fast_pulse_mode(fast_pulse_mode),
        .fast_width     (fast_width),
        .slow_en        (slow_en),
        .slow_pulse_mode(slow_pulse_mode),
        .slow_width     (slow_width),
        .fast_clk       (fast_clk),
        .fast_oe        (fast_oe),
        .slow_clk       (slow_clk),
        .slow_oe        (slow_oe)
    );

    // reference model state
    int k = 0;
    bit m_l [2];
    int w_l [2];
    logic exp_out [2];
    logic exp_oe  [2];
    string tag [2];
    logic prev_fast = 0, prev_slow = 0, prev_foe = 0, prev_soe = 0;

    function automatic int clampw(int w, int per);
        if (w == 0) return 1;
        if (w >= per) return per - 1;
        return w;
    endfunction

    function automatic logic level(int p, int per, bit pulse, int w);
        if (pulse) return (p < w);
        return (p < per / 2);
    endfunction

    task automatic chk(string t, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b k=%0d", t, what, act, exp, k);
        end
    endtask

    // called right after a posedge, with the inputs the DUT just sampled
    task automatic model_edge();
        int per [2];
        bit md [2];
        int wd [2];
        bit en [2];
        per[0] = FP; per[1] = SP;
        md[0] = fast_pulse_mode; md[1] = slow_pulse_mode;
        wd[0] = int'(fast_width); wd[1] = int'(slow_width);
        en[0] = fast_en; en[1] = slow_en;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                exp_out[c] = 0; exp_oe[c] = 0; tag[c] = "R1";
            end
            k = 0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                int p = k % per[c];
                if (p == 0) begin
                    m_l[c] = md[c];
                    w_l[c] = clampw(wd[c], per[c]);
                end
                exp_oe[c]  = en[c];
                exp_out[c] = en[c] ? level(p, per[c], m_l[c], w_l[c]) : 1'b0;
                if (!en[c]) tag[c] = "R7";
                else if (m_l[c]) tag[c] = (wd[c] == 0 || wd[c] >= per[c]) ? "R4 R5 R6" : "R4 R6";
                else tag[c] = "R2 R3";
            end
            k++;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag[0], "fast_clk", fast_clk, exp_out[0]);
        chk(tag[0], "fast_oe",  fast_oe,  exp_oe[0]);
        chk(tag[1], "slow_clk", slow_clk, exp_out[1]);
        chk(tag[1], "slow_oe",  slow_oe,  exp_oe[1]);
        if (rst_n && slow_clk && !prev_slow && prev_soe && prev_foe && fast_oe)
            chk("R8", "fast rise with slow rise", fast_clk && !prev_fast, 1'b1);
        prev_fast = fast_clk; prev_slow = slow_clk;
        prev_foe = fast_oe; prev_soe = slow_oe;
    endtask

    function automatic logic [CW-1:0] pick_w(int per);
        case ($urandom_range(0, 5))
            0: return '0;
            1: return CW'(per - 1);
            2: return CW'(per);
            3: return '1;
            default: return CW'($urandom_range(1, per - 1));
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        m_l[0] = 0; m_l[1] = 0; w_l[0] = FP / 2; w_l[1] = SP / 2;
        // R1: reset state
        for (int i = 0; i < 3; i++) step();
        rst_n = 1'b1;
        // R2 R3 R8: both square for two slow periods
        for (int i = 0; i < 2 * SP; i++) step();
        // R5: extreme widths in pulse mode
        fast_pulse_mode = 1; fast_width = '0;
        slow_pulse_mode = 1; slow_width = 14'd16000;
        for (int i = 0; i < SP; i++) step();
        // R6: change mid-period, old settings must persist
        fast_width = 14'd1000; slow_width = 14'd3000;
        while ((k % FP) != 500) step();
        fast_width = 14'd10; fast_pulse_mode = 0;
        for (int i = 0; i < 2 * FP; i++) step();
        // R1: reset asserted mid-run
        while ((k % FP) != 777) step();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step();
        rst_n = 1'b1;
        // random mix, R7 enable toggles included
        for (int i = 0; i < RUN / 2; i++) begin
            step();
            if ($urandom_range(0, 699) == 0) begin
                fast_en = ($urandom_range(0, 3) != 0);
                slow_en = ($urandom_range(0, 3) != 0);
                fast_pulse_mode = $urandom_range(0, 1);
                slow_pulse_mode = $urandom_range(0, 1);
                fast_width = pick_w(FP);
                slow_width = pick_w(SP);
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule